// File: doc/BRIEF.md
# Selectable Watchdog Timer

This block watches a processor heartbeat. The processor proves it is alive by pulling the active-low kick line from high to low often enough. If no such falling edge arrives within the selected timeout, the block drives its active-low alarm output low for a fixed number of millisecond ticks. It then releases the output and starts a fresh timeout interval on its own.

A two-bit code selects the timeout. The code is delivered as a static input by the surrounding register logic. One code value switches the watchdog off entirely, and that value is the reset default. Time is measured in ticks of an external millisecond strobe. While the system runs from its backup battery, the strobe is gated off, so the timebase stands still and resumes where it left off once main power returns.

The kick line is asynchronous. It passes through a two-flop synchroniser and an edge detector on the system clock. A falling edge therefore acts on the third rising clock edge after the line goes low, and a low level must persist for at least one clock to be seen.

Top module: `wdt_watchdog`

## Requirements
- R1: During and after reset the alarm output is high and the watchdog is off, because the reset default of the period code is 2'b11.
- R2: Period code 2'b00 gives a timeout of 800 ticks, 2'b01 gives 400 ticks and 2'b10 gives 150 ticks. After a restart, the alarm goes low on the clock edge that counts the last tick of the interval.
- R3: A falling edge on the kick line restarts the timeout count. It takes effect on the third rising clock edge after the line goes low.
- R4: The alarm output stays low for exactly 150 ticks and then returns high. A full new timeout interval starts at that moment.
- R5: While the battery-backup flag is high, millisecond ticks are not counted. Counting resumes from the frozen value when the flag falls.
- R6: Any change of the period code restarts the count on the next clock edge, measured with the new period.
- R7: Selecting code 2'b11 forces the alarm output high on the next clock edge, cancels any pulse in progress and clears the count.
- R8: A falling kick edge during the alarm pulse neither shortens nor extends the pulse. The next interval is still a full period from the end of the pulse.
- R9: Only falling edges kick. A rising edge, or a kick line held low, does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_n | input | 1 | Asynchronous heartbeat line; a falling edge restarts the timeout |
| ms_tick | input | 1 | One-clock strobe, once per millisecond |
| on_battery | input | 1 | High while running from the backup supply; freezes the timebase |
| period_code | input | 2 | Timeout select: 00 = 800, 01 = 400, 10 = 150 ticks, 11 = off |
| wdt_out_n | output | 1 | Active-low watchdog alarm pulse |

## Verification
The bench measures each timeout to the exact clock edge, counting from a period-code change and from a kick. A synchroniser with one stage too many or too few, or an off-by-one terminal count, therefore shows up as a timeout one edge early or late. It also holds the battery flag across part of an interval, which catches a timebase that resets instead of freezing and one that keeps running. It kicks during the alarm pulse and turns the watchdog off mid-pulse, which catches a pulse that restarts or a disable that waits for the pulse to end. A long random run with kicks, tick gaps, battery bursts and code changes is then compared cycle by cycle against a behavioural model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WS_OFF   = 2'd0,
    WS_RUN   = 2'd1,
    WS_PULSE = 2'd2
  } wdt_state_e;

  localparam logic [1:0] SEL_OFF = 2'b11;

  // Map a period code to its timeout length in ticks; 0 means off.
  function automatic int unsigned sel_to_ticks(input logic [1:0] sel,
                                               input int unsigned t_long,
                                               input int unsigned t_mid,
                                               input int unsigned t_short);
    case (sel)
      2'b00:   return t_long;
      2'b01:   return t_mid;
      2'b10:   return t_short;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  // chain[0] is the first capture flop; chain[STAGES] is the delayed copy.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];

  a_r9_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase (
  input  logic tick,
  input  logic backup,
  output logic step
);
  // The timebase halts completely while on battery.
  assign step = tick & ~backup;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned T_LONG  = 800,
  parameter int unsigned T_MID   = 400,
  parameter int unsigned T_SHORT = 150,
  parameter int unsigned T_PULSE = 150,
  parameter int unsigned CW      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       kick,
  input  logic       step,
  output logic       alarm_n
);
  wdt_state_e    state;
  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  logic [CW-1:0] lim;
  logic          sel_chg;
  logic          sel_off;
  logic          run_done;
  logic          pulse_done;

  assign lim        = CW'(sel_to_ticks(sel, T_LONG, T_MID, T_SHORT));
  assign sel_chg    = (sel != sel_q);
  assign sel_off    = (sel == SEL_OFF);
  assign run_done   = step && (cnt == lim - 1'b1);
  assign pulse_done = step && (cnt == CW'(T_PULSE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WS_OFF;
      cnt   <= '0;
      sel_q <= SEL_OFF;
    end else begin
      sel_q <= sel;
      if (sel_off) begin
        state <= WS_OFF;
        cnt   <= '0;
      end else if (sel_chg || state == WS_OFF) begin
        state <= WS_RUN;
        cnt   <= '0;
      end else if (state == WS_RUN) begin
        if (kick) begin
          cnt <= '0;
        end else if (run_done) begin
          state <= WS_PULSE;
          cnt   <= '0;
        end else if (step) begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        // Pulse: kicks are ignored, only ticks advance it.
        if (pulse_done) begin
          state <= WS_RUN;
          cnt   <= '0;
        end else if (step) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign alarm_n = (state != WS_PULSE);

  a_r7_off_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    sel_off |=> alarm_n);

  a_r2_run_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_RUN && !sel_chg && !sel_off) |-> (cnt < lim));

  a_r4_pulse_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_PULSE) |-> (cnt < CW'(T_PULSE)));

  a_r5_frozen_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_RUN && !step && !kick && !sel_chg && !sel_off) |=> $stable(cnt));

  a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_RUN && kick && !sel_chg && !sel_off) |=> (cnt == '0 && state == WS_RUN));

  a_r8_pulse_ignores_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_PULSE && kick && !step && !sel_chg && !sel_off) |=> (state == WS_PULSE));

endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned T_LONG      = 800,
  parameter int unsigned T_MID       = 400,
  parameter int unsigned T_SHORT     = 150,
  parameter int unsigned T_PULSE     = 150,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_n,
  input  logic       ms_tick,
  input  logic       on_battery,
  input  logic [1:0] period_code,
  output logic       wdt_out_n
);
  localparam int unsigned TMAX = max2(max2(T_LONG, T_MID), max2(T_SHORT, T_PULSE));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic kick_fall;
  logic tb_step;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (kick_n),
    .fall (kick_fall)
  );

  wdt_timebase u_tb (
    .tick  (ms_tick),
    .backup(on_battery),
    .step  (tb_step)
  );

  wdt_core #(
    .T_LONG (T_LONG),
    .T_MID  (T_MID),
    .T_SHORT(T_SHORT),
    .T_PULSE(T_PULSE),
    .CW     (CW)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (period_code),
    .kick   (kick_fall),
    .step   (tb_step),
    .alarm_n(wdt_out_n)
  );

  a_r1_high_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> wdt_out_n);

endmodule

// File: tb/wdt_watchdog_tb.sv
module wdt_watchdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kick_n = 1'b1;
  logic       ms_tick = 1'b1;
  logic       on_battery = 1'b0;
  logic [1:0] period_code = 2'b11;
  logic       wdt_out_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  wdt_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .kick_n(kick_n), .ms_tick(ms_tick),
    .on_battery(on_battery), .period_code(period_code), .wdt_out_n(wdt_out_n)
  );

  function automatic int ticks_for(input logic [1:0] c);
    case (c)
      2'b00:   return 800;
      2'b01:   return 400;
      2'b10:   return 150;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Negedges until the alarm goes low (counting from the current negedge).
  task automatic wait_low(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (wdt_out_n && k < 5000);
  endtask

  task automatic wait_high(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!wdt_out_n && k < 5000);
  endtask

  // Behavioural model built from the requirements
  logic [2:0] m_h;
  logic [1:0] m_sel;
  int m_st, m_cnt;
  always @(posedge clk) begin
    bit f, s;
    int lim;
    if (!rst_n) begin
      m_h = 3'b111; m_sel = 2'b11; m_st = 0; m_cnt = 0;
    end else begin
      f = m_h[2] & ~m_h[1];
      m_h = {m_h[1:0], kick_n};
      s = ms_tick & ~on_battery;
      lim = ticks_for(period_code);
      if (period_code == 2'b11) begin m_st = 0; m_cnt = 0; end
      else if (period_code != m_sel || m_st == 0) begin m_st = 1; m_cnt = 0; end
      else if (m_st == 1) begin
        if (f) m_cnt = 0;
        else if (s) begin
          if (m_cnt == lim - 1) begin m_st = 2; m_cnt = 0; end
          else m_cnt++;
        end
      end else if (s) begin
        if (m_cnt == 149) begin m_st = 1; m_cnt = 0; end
        else m_cnt++;
      end
      m_sel = period_code;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) chk("R2-R9 model compare", int'(wdt_out_n), (m_st == 2) ? 0 : 1);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    logic [1:0] codes [3];
    codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b10;
    void'($urandom(32'd2718));

    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(wdt_out_n), 1);
    rst_n = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R1 off default", int'(wdt_out_n), 1);

    // R2 / R4 for each period code
    for (int i = 0; i < 3; i++) begin
      period_code = codes[i];
      wait_low(k);   chk("R2 timeout", k, ticks_for(codes[i]) + 1);
      wait_high(k);  chk("R4 pulse length", k, 150);
      wait_low(k);   chk("R4 next interval", k, ticks_for(codes[i]));
      if (i < 2) begin
        wait_high(k);
        @(negedge clk); period_code = 2'b11;
        @(negedge clk);
      end
    end
    // R7: disable mid pulse
    repeat (20) @(negedge clk);
    period_code = 2'b11;
    @(negedge clk);
    chk("R7 off cancels pulse", int'(wdt_out_n), 1);
    repeat (500) @(negedge clk);
    chk("R7 stays off", int'(wdt_out_n), 1);

    // R3: regular kicks keep it quiet
    period_code = 2'b01;
    k = 1;
    for (int j = 0; j < 10; j++) begin
      repeat (300) begin @(negedge clk); if (!wdt_out_n) k = 0; end
      kick_n = 1'b0; repeat (2) @(negedge clk); kick_n = 1'b1;
    end
    chk("R3 kicks hold off alarm", k, 1);
    @(negedge clk); kick_n = 1'b0;
    wait_low(k);  chk("R3 timeout from kick", k, 403);
    wait_high(k);
    // R9: line stays low (no new edge), then a rising edge
    @(negedge clk); period_code = 2'b10;
    repeat (50) @(negedge clk);
    kick_n = 1'b1;
    k = 50;
    do begin @(negedge clk); k++; end while (wdt_out_n && k < 5000);
    chk("R9 rising edge ignored", k, 151);
    wait_high(k);

    // R5: battery freezes timebase
    @(negedge clk); period_code = 2'b00;
    k = 0;
    repeat (100) @(negedge clk);
    on_battery = 1'b1;
    repeat (500) @(negedge clk);
    on_battery = 1'b0;
    k = 600;
    do begin @(negedge clk); k++; end while (wdt_out_n && k < 5000);
    chk("R5 frozen during backup", k, 1301);
    wait_high(k);

    // R6: code change restarts
    @(negedge clk); period_code = 2'b11;
    @(negedge clk); period_code = 2'b00;
    repeat (500) @(negedge clk);
    period_code = 2'b01;
    k = 500;
    do begin @(negedge clk); k++; end while (wdt_out_n && k < 5000);
    chk("R6 restart on change", k, 901);

    // R8: kick inside the pulse
    kick_n = 1'b0; repeat (2) @(negedge clk); kick_n = 1'b1;
    k = 2;
    do begin @(negedge clk); k++; end while (!wdt_out_n && k < 5000);
    chk("R8 pulse not altered", k, 150);
    wait_low(k);   chk("R8 full interval after pulse", k, 400);

    // Random phase checked against the model
    period_code = 2'b11;
    @(negedge clk);
    cmp_on = 1'b1;
    for (int c = 0; c < 30000; c++) begin
      ms_tick = ($urandom % 3) != 0;
      if (($urandom % 300) == 0) on_battery = ~on_battery;
      if (($urandom % 150) == 0) kick_n = ~kick_n;
      if (($urandom % 2500) == 0) period_code = 2'($urandom % 4);
      if (period_code == 2'b11 && ($urandom % 40) == 0) period_code = 2'($urandom % 3);
      @(negedge clk);
    end
    cmp_on = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule